// File: doc/BRIEF.md
# Floating-Point Register Boxing Unit

This block sits between a 64-bit floating-point register file and the datapath of a floating-point unit. It handles both directions of traffic.

On the writeback side it takes a result, a width tag and an instruction class, and builds the full 64-bit word that is written to the register. A single-precision result lands in the low 32 bits, and the high half is filled with ones. On the read side there are three independent operand ports, so a fused multiply-add can fetch all of its sources at once. Each port takes a 64-bit register word, the width the instruction expects and the instruction's class, and produces the operand the datapath sees.

A single-width operand is valid only when its high 32 bits are all ones. What happens to an invalid one depends on the class:
- **Computational instructions** (arithmetic, fused multiply-add, converts, compares, classify, sign-injection) silently replace it with the single-precision canonical NaN.
- **Transfers** (32-bit loads and stores, and bit moves between integer and float registers) forward the raw low bits without looking at the high half.

Double-width traffic passes through untouched. Every path is combinational. A per-port status bit marks an invalid box for debug visibility only. It has no architectural effect: no trap is raised and no exception flag is set.

Top module: `fp_nanbox_unit`

Encodings used on the ports:
- Width: 0 = double, 1 = single.
- Class: 0 = computational, 1 = transfer.
- The single-precision canonical NaN is 32'h7FC00000.
- For a single-width read, the operand sits in bits 31:0 and bits 63:32 are driven to 0.

## Requirements
- R1: With width 1 (single) on writeback, `wb_value_o[63:32]` is all ones and `wb_value_o[31:0]` equals `wb_result_i[31:0]`.
- R2: With width 0 (double) on writeback, `wb_value_o` equals `wb_result_i` in all 64 bits, NaN payloads included.
- R3: The writeback class input has no effect on `wb_value_o`. A transfer and a computational result with the same data and width produce the same word.
- R4: On a read port with width 1 and class 1 (transfer), the operand's bits 31:0 equal the register's bits 31:0 and bits 63:32 are 0. This holds even when the register's high half is not all ones.
- R5: On a read port with width 1 and class 0 (computational), when register bits 63:32 are all ones, the operand's bits 31:0 equal the register's bits 31:0 and bits 63:32 are 0.
- R6: On a read port with width 1 and class 0, when any of register bits 63:32 is 0 (even a single bit), the operand is 64'h00000000_7FC00000.
- R7: On a read port with width 0 (double), the operand equals the register word in all 64 bits for either class, and the status bit stays 0.
- R8: A port's `rd_box_bad_o` bit is 1 exactly when that port has width 1 and register bits 63:32 are not all ones, for either class. It changes no other output.
- R9: The three read ports are independent. Each port's operand and status depend only on that port's own register, width and class inputs.
- R10: A word produced by a single-width writeback, viewed as a double, is a negative quiet NaN: bit 63 is 1, bits 62:52 are all ones, and bit 51 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wb_result_i | input | 64 | Result from the datapath to be written back |
| wb_width_i | input | 1 | Writeback width: 0 double, 1 single |
| wb_class_i | input | 1 | Writeback class: 0 computational, 1 transfer |
| wb_value_o | output | 64 | Full register word to write |
| rd_reg_i | input | 3x64 | Register words for the read ports (index 0 = rs1, 1 = rs2, 2 = rs3) |
| rd_width_i | input | 3 | Per-port operand width: 0 double, 1 single |
| rd_class_i | input | 3 | Per-port class: 0 computational, 1 transfer |
| rd_operand_o | output | 3x64 | Per-port operand to the datapath |
| rd_box_bad_o | output | 3 | Per-port debug flag: single-width register with an invalid box |

## Verification
The unit holds no state, so a fault in its decision logic shows at the ports in the same cycle as the inputs that trigger it.

The faults most likely to go unnoticed are those that mix up the class rule: a transfer that substitutes the canonical NaN, or a computational read that lets a corrupt low half through. The bench catches these by pairing the same badly boxed register with both classes and by clearing a single high bit rather than the whole half. A port that leaks into its neighbour shows up when the three ports are given different widths, classes and box states in the same cycle.

// File: rtl/nanbox_pkg.sv
package nanbox_pkg;

    // Operand / result width tag
    typedef enum logic {
        W_DOUBLE = 1'b0,
        W_SINGLE = 1'b1
    } fwidth_e;

    // Instruction class: transfers skip the box check on read
    typedef enum logic {
        CLS_COMPUTE  = 1'b0,
        CLS_TRANSFER = 1'b1
    } fclass_e;

endpackage

// File: rtl/nanbox_box_check.sv
module nanbox_box_check #(
    parameter int UPPER_W = 32
) (
    input  logic [UPPER_W-1:0] upper_i,
    output logic               box_ok_o
);

    // A box is valid only when every upper bit is set
    always_comb begin
        box_ok_o = &upper_i;
    end

endmodule

// File: rtl/nanbox_writeback.sv
module nanbox_writeback
    import nanbox_pkg::*;
#(
    parameter int FLEN     = 64,
    parameter int NARROW_W = 32
) (
    input  logic [FLEN-1:0] result_i,
    input  logic            width_i,
    input  logic            class_i,
    output logic [FLEN-1:0] value_o
);

    localparam int UPPER_W = FLEN - NARROW_W;

    // Every narrow result is boxed, whatever its class
    always_comb begin
        if (width_i == W_SINGLE) begin
            value_o = {{UPPER_W{1'b1}}, result_i[NARROW_W-1:0]};
        end else begin
            value_o = result_i;
        end
    end

    always_comb begin
        if (!$isunknown({result_i, width_i, class_i})) begin
            if (width_i == W_SINGLE && (class_i == CLS_TRANSFER || class_i == CLS_COMPUTE)) begin
                p_boxed_upper_r1: assert (&value_o[FLEN-1:NARROW_W])
                    else $error("single writeback left upper bits unboxed");
                p_boxed_low_r1: assert (value_o[NARROW_W-1:0] == result_i[NARROW_W-1:0])
                    else $error("single writeback altered low bits");
            end
            if (width_i == W_DOUBLE) begin
                p_double_wb_r2: assert (value_o == result_i)
                    else $error("double writeback altered data");
            end
        end
    end

endmodule

// File: rtl/nanbox_read_port.sv
module nanbox_read_port
    import nanbox_pkg::*;
#(
    parameter int FLEN         = 64,
    parameter int NARROW_W     = 32,
    parameter int NARROW_EXP_W = 8
) (
    input  logic [FLEN-1:0] reg_i,
    input  logic            width_i,
    input  logic            class_i,
    output logic [FLEN-1:0] operand_o,
    output logic            box_bad_o
);

    localparam int UPPER_W  = FLEN - NARROW_W;
    localparam int FRAC_W   = NARROW_W - NARROW_EXP_W - 1;
    // Canonical quiet NaN: positive, exponent all ones, only the top fraction bit set
    localparam logic [NARROW_W-1:0] CANON_NAN =
        {1'b0, {NARROW_EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic box_ok;

    nanbox_box_check #(
        .UPPER_W (UPPER_W)
    ) u_check (
        .upper_i  (reg_i[FLEN-1:NARROW_W]),
        .box_ok_o (box_ok)
    );

    always_comb begin
        box_bad_o = (width_i == W_SINGLE) && !box_ok;
        if (width_i == W_DOUBLE) begin
            operand_o = reg_i;
        end else if (class_i == CLS_TRANSFER || box_ok) begin
            operand_o = {{UPPER_W{1'b0}}, reg_i[NARROW_W-1:0]};
        end else begin
            operand_o = {{UPPER_W{1'b0}}, CANON_NAN};
        end
    end

    always_comb begin
        if (!$isunknown({reg_i, width_i, class_i})) begin
            p_flag_single_only_r8: assert (!box_bad_o || width_i == W_SINGLE)
                else $error("box flag raised on a double operand");
            p_transfer_raw_r4: assert (!(width_i == W_SINGLE && class_i == CLS_TRANSFER)
                                       || operand_o[NARROW_W-1:0] == reg_i[NARROW_W-1:0])
                else $error("transfer read did not return raw low bits");
            p_subst_nan_r6: assert (!(box_bad_o && class_i == CLS_COMPUTE)
                                    || operand_o[NARROW_W-1:0] == CANON_NAN)
                else $error("bad box on computational read not replaced");
            p_single_upper_zero_r5: assert (width_i != W_SINGLE || operand_o[FLEN-1:NARROW_W] == '0)
                else $error("single operand upper bits not cleared");
        end
    end

endmodule

// File: rtl/fp_nanbox_unit.sv
module fp_nanbox_unit
    import nanbox_pkg::*;
#(
    parameter int FLEN         = 64,
    parameter int NARROW_W     = 32,
    parameter int NARROW_EXP_W = 8,
    parameter int NRD          = 3
) (
    input  logic [FLEN-1:0]          wb_result_i,
    input  logic                     wb_width_i,
    input  logic                     wb_class_i,
    output logic [FLEN-1:0]          wb_value_o,
    input  logic [NRD-1:0][FLEN-1:0] rd_reg_i,
    input  logic [NRD-1:0]           rd_width_i,
    input  logic [NRD-1:0]           rd_class_i,
    output logic [NRD-1:0][FLEN-1:0] rd_operand_o,
    output logic [NRD-1:0]           rd_box_bad_o
);

    // Wide-format exponent width follows the wide word (11 bits for 64)
    localparam int WIDE_EXP_W = (FLEN == 64) ? 11 : NARROW_EXP_W;
    localparam int WIDE_QBIT  = FLEN - 2 - WIDE_EXP_W;

    nanbox_writeback #(
        .FLEN     (FLEN),
        .NARROW_W (NARROW_W)
    ) u_wb (
        .result_i (wb_result_i),
        .width_i  (wb_width_i),
        .class_i  (wb_class_i),
        .value_o  (wb_value_o)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        nanbox_read_port #(
            .FLEN         (FLEN),
            .NARROW_W     (NARROW_W),
            .NARROW_EXP_W (NARROW_EXP_W)
        ) u_port (
            .reg_i     (rd_reg_i[p]),
            .width_i   (rd_width_i[p]),
            .class_i   (rd_class_i[p]),
            .operand_o (rd_operand_o[p]),
            .box_bad_o (rd_box_bad_o[p])
        );
    end

    // A boxed narrow word viewed at full width is a negative quiet NaN
    always_comb begin
        if (!$isunknown({wb_result_i, wb_width_i}) && wb_width_i == W_SINGLE) begin
            p_wide_qnan_view_r10: assert (wb_value_o[FLEN-1]
                                          && &wb_value_o[FLEN-2 -: WIDE_EXP_W]
                                          && wb_value_o[WIDE_QBIT])
                else $error("boxed word is not a negative quiet NaN at full width");
        end
    end

endmodule

// File: tb/tb_fp_nanbox_unit.sv
`timescale 1ns/1ps
module tb_fp_nanbox_unit;

    localparam int FLEN = 64;
    localparam int NRD  = 3;
    localparam logic [31:0] CNAN = 32'h7FC0_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [FLEN-1:0]          wb_result;
    logic                     wb_width, wb_class;
    logic [FLEN-1:0]          wb_value;
    logic [NRD-1:0][FLEN-1:0] rd_reg;
    logic [NRD-1:0]           rd_width, rd_class;
    logic [NRD-1:0][FLEN-1:0] rd_operand;
    logic [NRD-1:0]           rd_bad;

    fp_nanbox_unit dut (
        .wb_result_i  (wb_result),
        .wb_width_i   (wb_width),
        .wb_class_i   (wb_class),
        .wb_value_o   (wb_value),
        .rd_reg_i     (rd_reg),
        .rd_width_i   (rd_width),
        .rd_class_i   (rd_class),
        .rd_operand_o (rd_operand),
        .rd_box_bad_o (rd_bad)
    );

    typedef struct packed {
        logic [FLEN-1:0]          wb;
        logic [NRD-1:0][FLEN-1:0] op;
        logic [NRD-1:0]           bad;
        logic                     qnan_chk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Expected values built from the requirements
    function automatic logic [FLEN-1:0] model_wb(logic [FLEN-1:0] r, logic w);
        return w ? {32'hFFFF_FFFF, r[31:0]} : r;
    endfunction

    function automatic logic [FLEN-1:0] model_rd(logic [FLEN-1:0] r, logic w, logic c);
        if (!w) return r;
        if (c || r[63:32] == 32'hFFFF_FFFF) return {32'h0, r[31:0]};
        return {32'h0, CNAN};
    endfunction

    task automatic drive(input logic [FLEN-1:0] res, input logic ww, input logic wc,
                         input logic [NRD-1:0][FLEN-1:0] regs,
                         input logic [NRD-1:0] w, input logic [NRD-1:0] c,
                         input string tag);
        exp_t e;
        @(posedge clk);
        wb_result = res; wb_width = ww; wb_class = wc;
        rd_reg = regs; rd_width = w; rd_class = c;
        e.wb = model_wb(res, ww);
        for (int p = 0; p < NRD; p++) begin
            e.op[p]  = model_rd(regs[p], w[p], c[p]);
            e.bad[p] = w[p] && (regs[p][63:32] != 32'hFFFF_FFFF);
        end
        e.qnan_chk = ww;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected item per cycle, at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                tests++;
                if (wb_value !== e.wb) begin
                    fails++;
                    $display("FAIL %s wb_value act=%h exp=%h", t, wb_value, e.wb);
                end
                if (e.qnan_chk) begin
                    tests++;
                    if (!(wb_value[63] && &wb_value[62:52] && wb_value[51])) begin
                        fails++;
                        $display("FAIL R10 (%s) wide view act=%h exp=negative quiet NaN", t, wb_value);
                    end
                end
                for (int p = 0; p < NRD; p++) begin
                    tests++;
                    if (rd_operand[p] !== e.op[p]) begin
                        fails++;
                        $display("FAIL %s port%0d operand act=%h exp=%h", t, p, rd_operand[p], e.op[p]);
                    end
                    tests++;
                    if (rd_bad[p] !== e.bad[p]) begin
                        fails++;
                        $display("FAIL R8 (%s) port%0d flag act=%b exp=%b", t, p, rd_bad[p], e.bad[p]);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] good_s, bad1_s, bad0_s, dnan;
        good_s = 64'hFFFF_FFFF_3F80_0000;
        bad1_s = 64'hFFFF_7FFF_4049_0FDB;   // one upper bit clear
        bad0_s = 64'h0000_0000_C020_0000;   // whole upper half clear
        dnan   = 64'h7FF4_1234_5678_9ABC;   // signalling double NaN payload
        wb_result = '0; wb_width = 1'b0; wb_class = 1'b0;
        rd_reg = '0; rd_width = '0; rd_class = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset-state inputs: all zero, all double
        drive('0, 1'b0, 1'b0, '{64'h0, 64'h0, 64'h0}, 3'b000, 3'b000, "R2 R7 idle");
        // R1 single writeback, compute and transfer classes (R3)
        drive(64'h1234_5678_4049_0FDB, 1'b1, 1'b0, '{good_s, good_s, good_s}, 3'b111, 3'b000, "R1 R3 R5");
        drive(64'h1234_5678_4049_0FDB, 1'b1, 1'b1, '{good_s, good_s, good_s}, 3'b111, 3'b111, "R1 R3 R4");
        drive(64'h0000_0000_0000_0000, 1'b1, 1'b1, '{bad0_s, bad0_s, bad0_s}, 3'b111, 3'b111, "R1 R4 bad box raw");
        // R2 double writeback preserves NaN payload, both classes
        drive(dnan, 1'b0, 1'b0, '{dnan, dnan, dnan}, 3'b000, 3'b000, "R2 R7 compute");
        drive(dnan, 1'b0, 1'b1, '{dnan, bad0_s, good_s}, 3'b000, 3'b111, "R2 R3 R7 transfer");
        // R6 substitution on one clear bit and all clear
        drive(64'h0, 1'b0, 1'b0, '{bad1_s, bad1_s, bad1_s}, 3'b111, 3'b000, "R6 single bit");
        drive(64'h0, 1'b0, 1'b0, '{bad0_s, bad0_s, bad0_s}, 3'b111, 3'b000, "R6 all clear");
        // R9 mixed per-port settings in one cycle
        drive(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, '{bad1_s, good_s, dnan}, 3'b011, 3'b100, "R9 mix A");
        drive(64'h8000_0000_7F80_0000, 1'b1, 1'b1, '{good_s, bad0_s, bad1_s}, 3'b110, 3'b010, "R9 mix B");
        drive(64'h8000_0000_7F80_0000, 1'b0, 1'b0, '{bad0_s, dnan, bad1_s}, 3'b101, 3'b001, "R9 mix C");
        // R5 valid box with sign bit set low half
        drive(64'h0, 1'b1, 1'b0, '{64'hFFFF_FFFF_FFC0_0001, good_s, 64'hFFFF_FFFF_0000_0000},
              3'b111, 3'b000, "R5 R10 valid box");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule